// File: doc/BRIEF.md
# I2C Master Bus Command Engine

This block sits under a small register bus and turns single software commands into conditions on an open-drain I2C bus. A write to the control register asks for a START, a repeated START or a STOP; a write to the data register sends one byte, MSB first, followed by a ninth clock on which the addressed device answers with ACK or NACK. The answer is captured and read back from the control register. Lines are driven only low: the block outputs drive-low requests for SCL and SDA and samples the wired SDA level.

Every bus step advances on a bit-timing tick that comes from outside, so the bus rate is set by whoever makes that tick. While a command runs, a busy status bit is high and further commands are refused. At the end of each command or byte a done status bit is set; it raises the interrupt line only when its enable is set. Status bits clear by writing ones to them. A data write made while busy is dropped and recorded in a sticky error bit.

Register map (2-bit address): 0 control, 1 data, 2 status, 3 interrupt enable.

Top module: `i2c_cmd_engine`

## Requirements
- R1: A control write while idle with bit 0 (enable) = 1, bits [2:1] = 1 and bit 3 = 0 produces a START: SDA is pulled low while SCL is released, then SCL is pulled low; SDA stays low afterwards.
- R2: The same write with bit 3 = 1 produces a repeated START: SDA is released and SCL is pulled low, SCL is released, then SDA is pulled low while SCL is high, then SCL is pulled low.
- R3: A control write with enable = 1 and bits [2:1] = 2 produces a STOP: SDA low while SCL low, SCL released, then SDA released; afterwards both lines are released and busy is low.
- R4: A control write with bits [2:1] = 0 or 3, or with enable = 0, starts nothing: busy stays low and both lines keep their levels. A data write while the stored enable is 0 is ignored.
- R5: A data write while idle and enabled sends the byte MSB first, one bit per two ticks (SCL low half, then SCL high half); SDA changes only while SCL is pulled low.
- R6: On the ninth clock SDA is released and the line level is sampled while SCL is high; afterwards control bit 3 reads 1 for NACK (line high) and 0 for ACK (line low), and SCL is left pulled low.
- R7: Status bit 7 (busy) is 1 from the cycle after an accepted command until its last bus step; control and data writes made while busy start nothing.
- R8: Status bit 3 (done) is set when a command or byte finishes; the interrupt output equals done AND bit 3 of the interrupt-enable register.
- R9: Writing 1 to a status bit clears it, writing 0 leaves it; status bits 6:4 and 1:0 always read 0.
- R10: A data write while busy is ignored and sets status bit 2 (error), which stays set until cleared by writing 1 to it.
- R11: Bus lines change only on cycles where the bit tick is high; with no tick, a running command holds its lines and stays busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| bit_tick | input | 1 | Bus timing tick, one bus step per pulse |
| sda_in | input | 1 | Sampled SDA line level |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| irq | output | 1 | Interrupt: done gated by its enable |

## Verification
The bench sends random and edge bytes (all zeros, all ones, single set bit at each end) and rebuilds each byte from the SDA level at each SCL release; a bit-order or shift error shows up as a wrong byte or a ninth bit that is not released. It pairs each byte with a random ACK or NACK answer, so a design that samples the line at the wrong half or inverts the sense reads back the wrong bit 3. It stops the tick in the middle of a command to catch a design that runs on the clock instead, and it writes data and control during a busy period, where a faulty design would start a second sequence, corrupt the byte or fail to raise the sticky error. START, repeated START and STOP are told apart by watching SDA edges while SCL is released.

// File: rtl/i2c_cmd_pkg.sv
// Shared types and register layout of the I2C command engine.
// Assumes a register width of at least 8 bits.
package i2c_cmd_pkg;
    typedef enum logic [1:0] {
        M_START = 2'd0,
        M_STOP  = 2'd1,
        M_BYTE  = 2'd2
    } seq_mode_t;

    // register addresses
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_DATA = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;
    localparam logic [1:0] A_IEN  = 2'd3;

    // control fields
    localparam int C_EN   = 0;
    localparam int C_CMD  = 1;   // two bits
    localparam int C_ACK  = 3;

    // command codes
    localparam logic [1:0] CMD_NONE  = 2'd0;
    localparam logic [1:0] CMD_START = 2'd1;
    localparam logic [1:0] CMD_STOP  = 2'd2;

    // status bits
    localparam int S_BUSY = 7;
    localparam int S_DONE = 3;
    localparam int S_ERR  = 2;
endpackage

// File: rtl/i2c_seq.sv
// Bus step sequencer: plays START, repeated START, STOP or one byte
// with its acknowledge clock, one step per bit_tick.
// Assumes go is raised only while busy is low.
module i2c_seq
    import i2c_cmd_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              go,
    input  seq_mode_t         go_mode,
    input  logic              go_restart,
    input  logic [DATA_W-1:0] go_data,
    input  logic              sda_in,
    output logic              busy,
    output logic              fin,
    output logic              nack,
    output logic              scl_lo,
    output logic              sda_lo
);
    localparam int STEP_W = $clog2(2 * DATA_W + 3);
    localparam logic [STEP_W-1:0] S0      = STEP_W'(0);
    localparam logic [STEP_W-1:0] S1      = STEP_W'(1);
    localparam logic [STEP_W-1:0] S2      = STEP_W'(2);
    localparam logic [STEP_W-1:0] S3      = STEP_W'(3);
    localparam logic [STEP_W-1:0] ACK_LO  = STEP_W'(2 * DATA_W);
    localparam logic [STEP_W-1:0] LAST_B  = STEP_W'(2 * DATA_W + 2);

    seq_mode_t         mode_q;
    logic              busy_q, scl_q, sda_q, nack_q;
    logic [STEP_W-1:0] step_q, last_q;
    logic [DATA_W-1:0] sh_q;
    logic              scl_n, sda_n;

    assign fin    = busy_q && tick && (step_q == last_q);
    assign busy   = busy_q;
    assign nack   = nack_q;
    assign scl_lo = scl_q;
    assign sda_lo = sda_q;

    // Line levels that the current step applies.
    always_comb begin
        scl_n = scl_q;
        sda_n = sda_q;
        case (mode_q)
            M_START: begin
                if (step_q == S0)      begin scl_n = 1'b1; sda_n = 1'b0; end
                else if (step_q == S1) begin scl_n = 1'b0; sda_n = 1'b0; end
                else if (step_q == S2) begin scl_n = 1'b0; sda_n = 1'b1; end
                else                   begin scl_n = 1'b1; sda_n = 1'b1; end
            end
            M_STOP: begin
                if (step_q == S0)      begin scl_n = 1'b1; sda_n = 1'b1; end
                else if (step_q == S1) begin scl_n = 1'b0; sda_n = 1'b1; end
                else                   begin scl_n = 1'b0; sda_n = 1'b0; end
            end
            default: begin
                if (step_q < ACK_LO) begin
                    scl_n = ~step_q[0];
                    sda_n = ~sh_q[DATA_W-1];
                end else if (step_q < LAST_B) begin
                    scl_n = ~step_q[0];
                    sda_n = 1'b0;
                end else begin
                    scl_n = 1'b1;
                    sda_n = 1'b0;
                end
            end
        endcase
    end

    // Command load, step advance, byte shift and acknowledge capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= M_START;
            busy_q <= 1'b0;
            scl_q  <= 1'b0;
            sda_q  <= 1'b0;
            nack_q <= 1'b0;
            step_q <= '0;
            last_q <= '0;
            sh_q   <= '0;
        end else if (go && !busy_q) begin
            busy_q <= 1'b1;
            mode_q <= go_mode;
            sh_q   <= go_data;
            step_q <= (go_mode == M_START && !go_restart) ? S2 : S0;
            case (go_mode)
                M_START: last_q <= S3;
                M_STOP:  last_q <= S2;
                default: last_q <= LAST_B;
            endcase
        end else if (busy_q && tick) begin
            scl_q <= scl_n;
            sda_q <= sda_n;
            if (mode_q == M_BYTE && step_q[0])
                sh_q <= sh_q << 1;
            if (step_q == last_q) begin
                busy_q <= 1'b0;
                if (mode_q == M_BYTE)
                    nack_q <= sda_in;
            end else begin
                step_q <= step_q + S1;
            end
        end
    end

    AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_BYTE && !scl_q && !$past(scl_q)) |-> $stable(sda_q)); // R5
    AST_NO_TICK_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !tick && !go) |=> ($stable(scl_q) && $stable(sda_q) && busy_q)); // R11
    AST_STOP_ENDS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && mode_q == M_STOP) |=> (!scl_q && !sda_q && !busy_q)); // R3
    AST_START_ENDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && mode_q == M_START) |=> (scl_q && sda_q)); // R1
    AST_ACK_LEAVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && mode_q == M_BYTE) |=> (scl_q && !sda_q)); // R6
endmodule

// File: rtl/i2c_regs.sv
// Register file: decodes control and data writes into sequencer
// commands, keeps done/error status (write-one-to-clear), interrupt
// enable, and drives read data. Assumes DATA_W >= 8.
module i2c_regs
    import i2c_cmd_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    input  logic              fin,
    input  logic              nack,
    output logic              go,
    output seq_mode_t         go_mode,
    output logic              go_restart,
    output logic [DATA_W-1:0] go_data,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic       en_q, ie_q, done_q, err_q;
    logic       wr_ctrl, wr_data, wr_stat, wr_ien;
    logic [1:0] cmd;

    assign wr_ctrl = wr && addr == A_CTRL;
    assign wr_data = wr && addr == A_DATA;
    assign wr_stat = wr && addr == A_STAT;
    assign wr_ien  = wr && addr == A_IEN;
    assign cmd     = wdata[C_CMD +: 2];

    // Command decode: only while idle and enabled.
    always_comb begin
        go         = 1'b0;
        go_mode    = M_BYTE;
        go_restart = wdata[C_ACK];
        go_data    = wdata;
        if (!busy) begin
            if (wr_ctrl && wdata[C_EN] && cmd == CMD_START) begin
                go = 1'b1; go_mode = M_START;
            end else if (wr_ctrl && wdata[C_EN] && cmd == CMD_STOP) begin
                go = 1'b1; go_mode = M_STOP;
            end else if (wr_data && en_q) begin
                go = 1'b1; go_mode = M_BYTE;
            end
        end
    end

    // Enable, interrupt enable and write-one-to-clear status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            ie_q   <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (wr_ctrl && !busy) en_q <= wdata[C_EN];
            if (wr_ien)           ie_q <= wdata[S_DONE];
            if (fin)                          done_q <= 1'b1;
            else if (wr_stat && wdata[S_DONE]) done_q <= 1'b0;
            if (wr_data && busy)              err_q <= 1'b1;
            else if (wr_stat && wdata[S_ERR]) err_q <= 1'b0;
        end
    end

    // Read data mux.
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin rdata[C_EN] = en_q; rdata[C_ACK] = nack; end
            A_STAT: begin
                rdata[S_BUSY] = busy;
                rdata[S_DONE] = done_q;
                rdata[S_ERR]  = err_q;
            end
            A_IEN:   rdata[S_DONE] = ie_q;
            default: rdata = '0;
        endcase
    end

    assign irq = done_q && ie_q;

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ie_q); // R8
    AST_DONE_AFTER_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> done_q); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !(wr_stat && wdata[S_ERR])) |=> err_q); // R10
    AST_BUSY_DATA_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && busy) |=> err_q); // R10
    AST_GO_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> busy); // R7
endmodule

// File: rtl/i2c_cmd_engine.sv
// Top of the I2C master command engine: register file plus bus
// sequencer. Assumes the SCL line is never stretched by a device.
module i2c_cmd_engine
    import i2c_cmd_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              bit_tick,
    input  logic              sda_in,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    output logic              irq
);
    logic              go, go_restart, busy, fin, nack;
    seq_mode_t         go_mode;
    logic [DATA_W-1:0] go_data;

    i2c_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .busy(busy), .fin(fin), .nack(nack),
        .go(go), .go_mode(go_mode), .go_restart(go_restart),
        .go_data(go_data), .rdata(reg_rdata), .irq(irq)
    );

    i2c_seq #(.DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(bit_tick), .go(go),
        .go_mode(go_mode), .go_restart(go_restart), .go_data(go_data),
        .sda_in(sda_in), .busy(busy), .fin(fin), .nack(nack),
        .scl_lo(scl_drive_low), .sda_lo(sda_drive_low)
    );
endmodule

// File: tb/tb_i2c_cmd_engine.sv
module tb_i2c_cmd_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       bit_tick = 1'b0;
    logic       scl_lo, sda_lo, irq;
    logic       slave_nack = 1'b1;
    logic       tick_en = 1'b1;
    logic [1:0] tcnt = 2'd0;
    logic       sda_in;

    int checks = 0, failures = 0;
    int starts = 0, stops = 0, ncap = 0;
    logic [8:0] cap = '0;
    logic p_scl = 1'b0, p_sda = 1'b0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    // slave answers ACK by holding SDA low for the whole byte
    assign sda_in = ~sda_lo & slave_nack;

    i2c_cmd_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bit_tick(bit_tick),
        .sda_in(sda_in), .scl_drive_low(scl_lo), .sda_drive_low(sda_lo),
        .irq(irq)
    );

    always @(posedge clk) begin
        tcnt     <= tcnt + 2'd1;
        bit_tick <= tick_en && (tcnt == 2'd3);
    end

    // bus monitor, master drive only
    always @(negedge clk) begin
        if (rst_n) begin
            if (!p_scl && !scl_lo && !p_sda && sda_lo) starts++;
            if (!p_scl && !scl_lo && p_sda && !sda_lo) stops++;
            if (p_scl && !scl_lo) begin cap = {cap[7:0], ~sda_lo}; ncap++; end
        end
        p_scl = scl_lo;
        p_sda = sda_lo;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        for (int i = 0; i < 400; i++) begin
            rd(2'd2, v);
            if (!v[7]) return;
        end
    endtask

    function automatic logic [8:0] exp_cap(input logic [7:0] b);
        return {b, 1'b1};
    endfunction

    task automatic send_byte(input logic [7:0] b, input logic nk, input bit poke);
        logic [7:0] v;
        int s0, p0;
        slave_nack = nk;
        ncap = 0; s0 = starts; p0 = stops;
        wr(2'd1, b);
        if (poke) begin
            wr(2'd1, ~b);                 // R10 ignored while busy
            wr(2'd0, 8'h05);              // R7 stop refused while busy
        end
        wait_idle();
        chk(cap == exp_cap(b) && ncap == 9, "R5 byte bits", cap, exp_cap(b));
        chk(starts == s0 && stops == p0, "R7 no extra condition", stops - p0, 0);
        rd(2'd0, v);
        chk(v[3] == nk, "R6 ack readback", v[3], nk);
        chk(scl_lo && !sda_lo, "R6 scl held low", {scl_lo, sda_lo}, 2'b10);
        rd(2'd2, v);
        chk(v[3], "R8 done after byte", v, 8'h08);
        wr(2'd2, 8'h08);
    endtask

    initial begin
        logic [7:0] v;
        int s0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(2'd2, v);
        chk(v == 8'h00, "R9 reset status", v, 0);
        chk(!scl_lo && !sda_lo && !irq, "R1 reset lines", {scl_lo, sda_lo, irq}, 0);

        // R4 no-action and disabled commands
        wr(2'd0, 8'h01);
        wr(2'd0, 8'h02);
        wr(2'd0, 8'h07);
        repeat (12) @(negedge clk);
        rd(2'd2, v);
        chk(v == 8'h00 && starts == 0, "R4 no action", v, 0);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h5A);
        repeat (12) @(negedge clk);
        rd(2'd2, v);
        chk(v == 8'h00 && !scl_lo && !sda_lo, "R4 data while disabled", v, 0);

        // R1 START, with tick paused (R11)
        wr(2'd3, 8'h08);
        tick_en = 1'b0;
        repeat (3) @(negedge clk);
        wr(2'd0, 8'h03);
        repeat (20) @(negedge clk);
        rd(2'd2, v);
        chk(v[7] && !scl_lo && !sda_lo, "R11 hold without tick", v, 8'h80);
        tick_en = 1'b1;
        wait_idle();
        chk(starts == 1, "R1 start seen", starts, 1);
        chk(scl_lo && sda_lo, "R1 lines after start", {scl_lo, sda_lo}, 2'b11);
        chk(irq, "R8 irq when enabled", irq, 1);
        wr(2'd2, 8'h00);
        rd(2'd2, v);
        chk(v[3], "R9 write zero keeps", v, 8'h08);
        wr(2'd2, 8'h08);
        rd(2'd2, v);
        chk(v == 8'h00 && !irq, "R9 w1c clears", v, 0);

        // directed byte corners, first one with busy writes
        send_byte(8'h00, 1'b0, 1'b1);
        rd(2'd2, v);
        chk(v[2], "R10 error set", v, 8'h04);
        send_byte(8'hFF, 1'b1, 1'b0);
        rd(2'd2, v);
        chk(v[2], "R10 error sticky", v, 8'h04);
        wr(2'd2, 8'h04);
        rd(2'd2, v);
        chk(!v[2], "R10 error cleared", v, 0);
        send_byte(8'h80, 1'b0, 1'b0);
        send_byte(8'h01, 1'b1, 1'b0);
        for (int i = 0; i < 16; i++)
            send_byte(8'($urandom), 1'($urandom), 1'b0);

        // R2 repeated start after a byte
        s0 = starts;
        wr(2'd0, 8'h0B);
        wait_idle();
        chk(starts == s0 + 1 && scl_lo && sda_lo, "R2 repeated start", starts - s0, 1);
        send_byte(8'hA5, 1'b0, 1'b0);

        // R8 irq masked
        wr(2'd3, 8'h00);
        s0 = stops;
        wr(2'd0, 8'h05);
        wait_idle();
        chk(stops == s0 + 1, "R3 stop seen", stops - s0, 1);
        chk(!scl_lo && !sda_lo, "R3 lines released", {scl_lo, sda_lo}, 0);
        rd(2'd2, v);
        chk(v == 8'h08 && !irq, "R8 masked irq", {v, irq}, 9'h010);

        if (!done_flag) begin
            done_flag = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
        $finish;
    end
endmodule